// File: doc/BRIEF.md
# Floating-point issue interlock

This block is the hazard checker in the decode stage of an in-order pipeline. The pipeline has one single-cycle integer unit (also used for loads) and three floating-point units: an adder with four pipelined stages, a multiplier with seven pipelined stages, and a divider that is not pipelined and stays busy for twenty-four cycles. Each cycle the block receives one candidate instruction: its unit class, its destination register, its two source registers and a valid flag. It answers with either issue or stall.

Internally the block follows every issued instruction. For each execute stage it records whether the stage is occupied and which register that instruction will write. It also keeps a shift register that books the future cycles in which the single register write port is already taken. The candidate is held when any of four checks fails: the write port is taken in the cycle it would need, the divider is busy, one of its sources is still being produced, or its destination matches an older floating-point instruction that is still executing. Otherwise it issues, and its reservation and destination enter the tracking state on the same clock edge. The decode stage keeps presenting a stalled instruction, and everything behind it waits.

Top module: `fp_issue_interlock`

## Requirements
- R1: A synchronous reset clears all write-port bookings, stage occupancy and the divider busy count. After reset, the first candidate of any class issues at once.
- R2: When `cand_valid` is 0, `issue` and `stall` are both 0 and the tracking state is left alone. Bubbles placed between a producer and a consumer do not change the cycle in which the consumer issues.
- R3: For a valid candidate, exactly one of `issue` and `stall` is 1. `stall` is 1 exactly when at least one of the checks R4 to R7 fails.
- R4: `cand_unit` encodes 0 = integer, 1 = load, 2 = FP add, 3 = FP multiply, 4 = FP divide. An instruction issued in cycle t writes the register file in cycle t+3 (integer, load), t+6 (add), t+9 (multiply) or t+26 (divide). A candidate stalls when its write cycle is already booked.
- R5: After a divide issues, another divide issues no earlier than 24 cycles later.
- R6: A consumer that reads a register written by an issued producer issues no earlier than 1 (integer), 2 (load), 4 (add), 7 (multiply) or 24 (divide) cycles after the producer. This gives 0, 1, 3, 6 or 23 stall cycles when the consumer follows directly.
- R7: A candidate stalls while its destination equals that of an instruction in adder stages 1 to 4, multiplier stages 1 to 7 or the busy divider. An integer or load instruction in its execute cycle does not cause this stall.
- R8: Unit codes 5, 6 and 7 are handled as integer instructions.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| cand_valid | input | 1 | Decode stage holds a real instruction |
| cand_unit | input | 3 | Unit class of the candidate (see R4, R8) |
| cand_dst | input | REG_BITS | Destination register |
| cand_src_a | input | REG_BITS | First source register |
| cand_src_b | input | REG_BITS | Second source register |
| issue | output | 1 | Candidate leaves decode at this clock edge |
| stall | output | 1 | Candidate and everything behind it hold |

## Verification
Directed pairs put a producer of each class directly in front of a dependent consumer, so the number of stall cycles shows the latency of each class on its own. Further pairs share only a destination, or share only a write cycle, so a write-after-write stall can be told apart from a write-port collision. Back-to-back divides separate the divider busy rule from the operand rule. Bubble runs and a reset in the middle of a divide show that idle cycles keep the tracking state and that reset clears it. A long pseudo-random mix over a small register set is then compared, cycle by cycle, with a reference model that simply keeps a list of in-flight instructions and their ages.

// File: rtl/fpil_pkg.sv
package fpil_pkg;

  typedef enum logic [2:0] {
    U_INT  = 3'd0,
    U_LOAD = 3'd1,
    U_FADD = 3'd2,
    U_FMUL = 3'd3,
    U_FDIV = 3'd4
  } unit_e;

  // Codes above the divider are handled as plain integer work.
  function automatic unit_e norm_unit(input logic [2:0] code);
    return (code > 3'd4) ? U_INT : unit_e'(code);
  endfunction

  // Cycles from issue to the write-port cycle: the execute stages, one memory stage, then writeback.
  function automatic int wb_offset(input unit_e u, input int add_n, input int mul_n, input int div_n);
    case (u)
      U_FADD:  return add_n + 2;
      U_FMUL:  return mul_n + 2;
      U_FDIV:  return div_n + 2;
      default: return 3;
    endcase
  endfunction

  // Earliest issue distance for a dependent consumer (latency plus one).
  function automatic int result_lag(input unit_e u, input int add_n, input int mul_n, input int div_n);
    case (u)
      U_LOAD:  return 2;
      U_FADD:  return add_n;
      U_FMUL:  return mul_n;
      U_FDIV:  return div_n;
      default: return 1;
    endcase
  endfunction

  function automatic int max3(input int a, input int b, input int c);
    int m;
    m = (a > b) ? a : b;
    return (m > c) ? m : c;
  endfunction

endpackage

// File: rtl/fpil_stage_pipe.sv
module fpil_stage_pipe #(
  parameter int DEPTH = 4,
  parameter int DW    = 5
) (
  input  logic                      clk,
  input  logic                      rst,
  input  logic                      push,
  input  logic [DW-1:0]             push_dst,
  input  logic                      push_tag,
  output logic [DEPTH-1:0]          stg_vld,
  output logic [DEPTH-1:0][DW-1:0]  stg_dst,
  output logic [DEPTH-1:0]          stg_tag
);

  // Entry stage takes the newly issued instruction.
  always_ff @(posedge clk) begin
    if (rst) begin
      stg_vld[0] <= 1'b0;
      stg_dst[0] <= '0;
      stg_tag[0] <= 1'b0;
    end else begin
      stg_vld[0] <= push;
      stg_dst[0] <= push_dst;
      stg_tag[0] <= push_tag;
    end
  end

  // Later stages advance every cycle; decode stalls do not hold execute.
  for (genvar k = 1; k < DEPTH; k++) begin : g_stage
    always_ff @(posedge clk) begin
      if (rst) begin
        stg_vld[k] <= 1'b0;
        stg_dst[k] <= '0;
        stg_tag[k] <= 1'b0;
      end else begin
        stg_vld[k] <= stg_vld[k-1];
        stg_dst[k] <= stg_dst[k-1];
        stg_tag[k] <= stg_tag[k-1];
      end
    end
  end

endmodule

// File: rtl/fpil_div_busy.sv
module fpil_div_busy #(
  parameter int CYCLES = 24,
  parameter int DW     = 5
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          start,
  input  logic [DW-1:0] start_dst,
  output logic          busy,
  output logic          early,
  output logic [DW-1:0] owner
);

  localparam int CW = $clog2(CYCLES + 1);

  logic [CW-1:0] left_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      left_q <= '0;
      owner  <= '0;
    end else if (start) begin
      left_q <= CW'(CYCLES);
      owner  <= start_dst;
    end else if (left_q != '0) begin
      left_q <= left_q - CW'(1);
    end
  end

  // busy: the divide still sits in its execute stage.
  // early: more than its last cycle remains, so the result and the unit are not free yet.
  assign busy  = (left_q != '0);
  assign early = (left_q > CW'(1));

  assert_div_free_R5: assert property (@(posedge clk) disable iff (rst)
    start |-> (left_q <= CW'(1)));

  assert_div_count_R5: assert property (@(posedge clk) disable iff (rst)
    (left_q != '0 && !start) |=> (left_q == $past(left_q) - CW'(1)));

endmodule

// File: rtl/fpil_wb_slots.sv
module fpil_wb_slots #(
  parameter int SLOTS = 27,
  parameter int OFF_W = 5
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [OFF_W-1:0] want_off,
  input  logic             book,
  output logic             taken
);

  // Bit n set: the write port is already booked n cycles from now.
  logic [SLOTS-1:0] slot_q;
  logic [SLOTS-1:0] book_vec;

  assign taken = slot_q[want_off];

  always_comb begin
    book_vec = '0;
    if (book) book_vec[want_off - OFF_W'(1)] = 1'b1;
  end

  always_ff @(posedge clk) begin
    if (rst) slot_q <= '0;
    else     slot_q <= (slot_q >> 1) | book_vec;
  end

  assert_port_unbooked_R4: assert property (@(posedge clk) disable iff (rst)
    book |-> !slot_q[want_off]);

  assert_port_keeps_R4: assert property (@(posedge clk) disable iff (rst)
    (slot_q[1] && !book) |=> slot_q[0]);

endmodule

// File: rtl/fp_issue_interlock.sv
module fp_issue_interlock
  import fpil_pkg::*;
#(
  parameter int REG_BITS   = 5,
  parameter int ADD_STAGES = 4,
  parameter int MUL_STAGES = 7,
  parameter int DIV_CYCLES = 24
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                cand_valid,
  input  logic [2:0]          cand_unit,
  input  logic [REG_BITS-1:0] cand_dst,
  input  logic [REG_BITS-1:0] cand_src_a,
  input  logic [REG_BITS-1:0] cand_src_b,
  output logic                issue,
  output logic                stall
);

  localparam int SLOTS = max3(ADD_STAGES, MUL_STAGES, DIV_CYCLES) + 3;
  localparam int OFF_W = $clog2(SLOTS);

  unit_e            u;
  logic [OFF_W-1:0] want_off;

  assign u        = norm_unit(cand_unit);
  assign want_off = OFF_W'(wb_offset(u, ADD_STAGES, MUL_STAGES, DIV_CYCLES));

  // Tracking state
  logic                          ex_vld, ex_ld;
  logic [REG_BITS-1:0]           ex_dst;
  logic [ADD_STAGES-1:0]         add_vld, add_tag;
  logic [ADD_STAGES-1:0][REG_BITS-1:0] add_dst;
  logic [MUL_STAGES-1:0]         mul_vld, mul_tag;
  logic [MUL_STAGES-1:0][REG_BITS-1:0] mul_dst;
  logic                          div_busy, div_early;
  logic [REG_BITS-1:0]           div_dst;
  logic                          port_taken;

  fpil_stage_pipe #(.DEPTH(1), .DW(REG_BITS)) u_ex (
    .clk(clk), .rst(rst),
    .push(issue && (u == U_INT || u == U_LOAD)),
    .push_dst(cand_dst), .push_tag(u == U_LOAD),
    .stg_vld(ex_vld), .stg_dst(ex_dst), .stg_tag(ex_ld)
  );

  fpil_stage_pipe #(.DEPTH(ADD_STAGES), .DW(REG_BITS)) u_add (
    .clk(clk), .rst(rst),
    .push(issue && u == U_FADD), .push_dst(cand_dst), .push_tag(1'b0),
    .stg_vld(add_vld), .stg_dst(add_dst), .stg_tag(add_tag)
  );

  fpil_stage_pipe #(.DEPTH(MUL_STAGES), .DW(REG_BITS)) u_mul (
    .clk(clk), .rst(rst),
    .push(issue && u == U_FMUL), .push_dst(cand_dst), .push_tag(1'b0),
    .stg_vld(mul_vld), .stg_dst(mul_dst), .stg_tag(mul_tag)
  );

  fpil_div_busy #(.CYCLES(DIV_CYCLES), .DW(REG_BITS)) u_div (
    .clk(clk), .rst(rst),
    .start(issue && u == U_FDIV), .start_dst(cand_dst),
    .busy(div_busy), .early(div_early), .owner(div_dst)
  );

  fpil_wb_slots #(.SLOTS(SLOTS), .OFF_W(OFF_W)) u_slots (
    .clk(clk), .rst(rst),
    .want_off(want_off), .book(issue), .taken(port_taken)
  );

  // Per-stage match vectors
  logic [ADD_STAGES-1:0] add_waw, add_raw;
  logic [MUL_STAGES-1:0] mul_waw, mul_raw;

  for (genvar k = 0; k < ADD_STAGES; k++) begin : g_add_hit
    assign add_waw[k] = add_vld[k] && (add_dst[k] == cand_dst);
    if (k < ADD_STAGES - 1) begin : g_early
      assign add_raw[k] = add_vld[k] &&
                          ((add_dst[k] == cand_src_a) || (add_dst[k] == cand_src_b));
    end else begin : g_last
      assign add_raw[k] = 1'b0;   // last stage forwards in time
    end
  end

  for (genvar k = 0; k < MUL_STAGES; k++) begin : g_mul_hit
    assign mul_waw[k] = mul_vld[k] && (mul_dst[k] == cand_dst);
    if (k < MUL_STAGES - 1) begin : g_early
      assign mul_raw[k] = mul_vld[k] &&
                          ((mul_dst[k] == cand_src_a) || (mul_dst[k] == cand_src_b));
    end else begin : g_last
      assign mul_raw[k] = 1'b0;
    end
  end

  // Named hazard events
  logic hz_port, hz_div, hz_raw, hz_waw, hz_any;

  assign hz_port = port_taken;
  assign hz_div  = (u == U_FDIV) && div_early;
  assign hz_raw  = (|add_raw) || (|mul_raw) ||
                   (ex_vld && ex_ld && ((ex_dst == cand_src_a) || (ex_dst == cand_src_b))) ||
                   (div_early && ((div_dst == cand_src_a) || (div_dst == cand_src_b)));
  assign hz_waw  = (|add_waw) || (|mul_waw) || (div_busy && (div_dst == cand_dst));
  assign hz_any  = hz_port || hz_div || hz_raw || hz_waw;

  assign issue = cand_valid && !hz_any;
  assign stall = cand_valid &&  hz_any;

  assert_bubble_quiet_R2: assert property (@(posedge clk) disable iff (rst)
    !cand_valid |-> (!issue && !stall));

  assert_one_answer_R3: assert property (@(posedge clk) disable iff (rst)
    cand_valid |-> $onehot({issue, stall}));

  assert_no_young_src_R6: assert property (@(posedge clk) disable iff (rst)
    (issue && add_vld[0]) |-> (add_dst[0] != cand_src_a && add_dst[0] != cand_src_b));

  assert_no_double_writer_R7: assert property (@(posedge clk) disable iff (rst)
    (issue && mul_vld[0]) |-> (mul_dst[0] != cand_dst));

  assert_div_dst_guard_R7: assert property (@(posedge clk) disable iff (rst)
    (issue && div_busy) |-> (div_dst != cand_dst));

endmodule

// File: tb/fp_issue_interlock_test.sv
module fp_issue_interlock_test;

  logic       clk = 1'b0;
  logic       rst;
  logic       cand_valid;
  logic [2:0] cand_unit;
  logic [4:0] cand_dst, cand_src_a, cand_src_b;
  logic       issue, stall;

  always #5 clk = ~clk;

  fp_issue_interlock uut (
    .clk(clk), .rst(rst), .cand_valid(cand_valid), .cand_unit(cand_unit),
    .cand_dst(cand_dst), .cand_src_a(cand_src_a), .cand_src_b(cand_src_b),
    .issue(issue), .stall(stall)
  );

  int vectors = 0;
  int miscompares = 0;
  int cyc = 0;
  bit done = 1'b0;

  always @(posedge clk) cyc <= cyc + 1;

  typedef struct { int unit; int dst; int p; } flight_t;
  flight_t fl[$];

  function automatic int t_off(int u);
    case (u) 2: return 6; 3: return 9; 4: return 26; default: return 3; endcase
  endfunction
  function automatic int t_lag(int u);
    case (u) 1: return 2; 2: return 4; 3: return 7; 4: return 24; default: return 1; endcase
  endfunction
  function automatic int t_depth(int u);
    case (u) 2: return 4; 3: return 7; 4: return 24; default: return 0; endcase
  endfunction

  // Reference: ages of in-flight instructions decide everything.
  function automatic bit model_go(int u, int d, int a, int b, output string why);
    int un = (u > 4) ? 0 : u;
    why = "";
    foreach (fl[i]) begin
      int age = cyc - fl[i].p;
      if (fl[i].p + t_off(fl[i].unit) == cyc + t_off(un)) why = {why, " R4-port"};
      if (un == 4 && fl[i].unit == 4 && age < 24)        why = {why, " R5-div"};
      if ((fl[i].dst == a || fl[i].dst == b) && age < t_lag(fl[i].unit)) why = {why, " R6-raw"};
      if (fl[i].unit >= 2 && age <= t_depth(fl[i].unit) && fl[i].dst == d) why = {why, " R7-waw"};
    end
    return (why == "");
  endfunction

  task automatic check(bit ok, string req, string what, int act, int exp);
    vectors++;
    if (!ok) begin
      miscompares++;
      $display("FAIL %s %s: actual %0d expected %0d (cycle %0d)", req, what, act, exp, cyc);
    end
  endtask

  // One cycle of stimulus; returns the expected issue.
  task automatic step(bit v, int u, int d, int a, int b, string req, output bit went);
    string why;
    bit go;
    @(negedge clk);
    while (fl.size() > 0 && cyc - fl[0].p > 40) void'(fl.pop_front());
    cand_valid = v; cand_unit = 3'(u); cand_dst = 5'(d);
    cand_src_a = 5'(a); cand_src_b = 5'(b);
    #1;
    go = v && model_go(u, d, a, b, why);
    check(issue === go && stall === (v && !go), req, {"issue/stall", why},
          int'({issue, stall}), int'({go, v && !go}));
    if (go) fl.push_back('{(u > 4) ? 0 : u, d, cyc});
    went = go;
  endtask

  task automatic bubbles(int n);
    bit w;
    for (int i = 0; i < n; i++) step(1'b0, 0, 0, 0, 0, "R2", w);
  endtask

  // Present an instruction until it issues (R3 hold); report stall count.
  task automatic send(int u, int d, int a, int b, string req, output int stalls);
    bit w;
    stalls = 0;
    for (int i = 0; i < 80; i++) begin
      step(1'b1, u, d, a, b, req, w);
      if (w) break;
      stalls++;
    end
  endtask

  task automatic expect_stalls(int u, int d, int a, int b, string req, int exp);
    int s;
    send(u, d, a, b, req, s);
    check(s == exp, req, "stall cycles", s, exp);
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst = 1'b1; cand_valid = 1'b0;
    repeat (2) @(negedge clk);
    fl.delete();
    rst = 1'b0;
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      miscompares++;
      vectors++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
    end
  end

  initial begin
    int s;
    bit w;
    rst = 1'b1; cand_valid = 1'b0; cand_unit = '0;
    cand_dst = '0; cand_src_a = '0; cand_src_b = '0;
    do_reset();

    // R1: reset state, every class issues at once
    expect_stalls(4, 1, 2, 3, "R1", 0);
    bubbles(30);

    // R6: producer/consumer distances per class
    expect_stalls(0, 1, 9, 9, "R6", 0); expect_stalls(0, 2, 1, 9, "R6", 0); bubbles(30);
    expect_stalls(1, 2, 9, 9, "R6", 0); expect_stalls(0, 3, 9, 2, "R6", 1); bubbles(30);
    expect_stalls(2, 3, 9, 9, "R6", 0); expect_stalls(0, 4, 3, 9, "R6", 3); bubbles(30);
    expect_stalls(3, 4, 9, 9, "R6", 0); expect_stalls(2, 5, 9, 4, "R6", 6); bubbles(30);
    expect_stalls(4, 5, 9, 9, "R6", 0); expect_stalls(0, 6, 5, 9, "R6", 23); bubbles(30);

    // R5: divider busy
    expect_stalls(4, 6, 9, 9, "R5", 0); expect_stalls(4, 7, 10, 10, "R5", 23); bubbles(30);

    // R7: destination match only
    expect_stalls(3, 8, 9, 9, "R7", 0); expect_stalls(2, 8, 10, 10, "R7", 7); bubbles(30);
    expect_stalls(4, 9, 1, 1, "R7", 0); expect_stalls(0, 9, 2, 2, "R7", 24); bubbles(30);
    expect_stalls(1, 10, 1, 1, "R7", 0); expect_stalls(0, 10, 2, 2, "R7", 0); bubbles(30);

    // R4: write-port collisions
    expect_stalls(3, 11, 1, 1, "R4", 0);
    expect_stalls(0, 12, 1, 1, "R4", 0);
    expect_stalls(0, 13, 1, 1, "R4", 0);
    expect_stalls(2, 14, 1, 1, "R4", 1);
    bubbles(30);
    // R2: bubbles keep bookings; integer after five idle cycles collides with the multiply
    expect_stalls(3, 15, 1, 1, "R4", 0);
    bubbles(5);
    expect_stalls(0, 16, 1, 1, "R2", 1);
    bubbles(30);

    // R8: codes 5..7 act as integer
    expect_stalls(2, 17, 1, 1, "R8", 0); expect_stalls(7, 18, 17, 1, "R8", 3);
    expect_stalls(5, 17, 18, 1, "R8", 0); bubbles(30);
    expect_stalls(6, 19, 1, 1, "R8", 0); expect_stalls(6, 20, 19, 19, "R8", 0); bubbles(30);

    // R1: reset in the middle of a divide frees everything
    expect_stalls(4, 21, 1, 1, "R1", 0);
    bubbles(3);
    do_reset();
    expect_stalls(4, 22, 21, 21, "R1", 0);
    bubbles(30);

    // R3: pseudo-random mix, stalled instructions are held
    begin
      int u = 0, d = 0, a = 0, b = 0;
      bit held = 1'b0;
      void'($urandom(7));
      for (int i = 0; i < 5000; i++) begin
        if (!held) begin
          u = $urandom_range(7); d = $urandom_range(7);
          a = $urandom_range(7); b = $urandom_range(7);
        end
        if (!held && $urandom_range(9) < 2) begin
          step(1'b0, 0, 0, 0, 0, "R2", w);
        end else begin
          step(1'b1, u, d, a, b, "R3", w);
          held = !w;
        end
      end
    end

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end

endmodule